// File: doc/BRIEF.md
# Eight-Digit Display Write Port

This block is the host-facing write side of an eight-character dot-matrix display controller. A host drives an 8-bit data bus, a 4-bit address and three active-low strobes: chip select, write and flash select. The write strobe is asynchronous to the controller clock. It is synchronised, and its falling edge is detected, so each low pulse produces exactly one store operation. The bus values are captured on the cycle that edge is seen.

Each accepted write goes to one of three stores. The character memory holds eight bytes: a 7-bit glyph code plus a font page bit. The flash memory holds one bit per digit. The control register holds the brightness, flash, blink, lamp-test and clear fields. Read ports give the refresh logic one character and flash bit per selected digit, the full flash vector and the control word.

Writing a control word with its top bit set starts a clear. The clear blanks every character to 20h and zeroes every flash bit. While it runs, character and flash writes are dropped. The clear ends on its own after a fixed number of clock cycles. It also ends when a control word with the top bit at zero arrives, but only once a minimum number of cycles has elapsed.

Top module: `disp_wr_port`

## Requirements
- R1: A write strobe pulse with `cs_n` high at the captured edge changes no store.
- R2: With `flsel_n`=1 and `addr[3]`=1, the whole `din` byte is stored in the character slot `addr[2:0]`. Bits 6..0 are the glyph code and bit 7 is the page bit. Digit 0 is the leftmost.
- R3: With `flsel_n`=1 and `addr[3]`=0, `din` is loaded into the control register, which appears unchanged on `ctrl_word`. Bit 7 is clear, bit 6 lamp test, bit 5 unused, bit 4 blink, bit 3 flash enable, and bits 2..0 brightness.
- R4: With `flsel_n`=0, `din[0]` becomes the flash bit of digit `addr[2:0]`. `din[7:1]` and `addr[3]` are ignored, and the character memory is not touched.
- R5: While `rst` is high, and on the cycle after it, every character reads 20h, every flash bit reads 0, `ctrl_word` reads 00h and `clear_busy` reads 0.
- R6: A control write with bit 7 set loads the control word as written, sets every character to 20h, clears every flash bit and raises `clear_busy`, all in the same cycle.
- R7: Left alone, `clear_busy` stays high for exactly `CLR_CYCLES` clock cycles and then falls.
- R8: A control write with bit 7 at zero ends a running clear in the cycle it commits, provided at least `MIN_CYCLES` cycles have passed since the clear began. Before that point the clear continues, but the control word is still loaded.
- R9: While `clear_busy` is high, character and flash writes are dropped.
- R10: A single strobe low pulse commits one write, using the bus values present when the falling edge is detected. Bus changes later in the same pulse are not stored.
- R11: A write becomes visible on the read ports in the third clock edge after the first edge that samples `wr_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| flsel_n | input | 1 | Flash store select, active low |
| addr | input | 4 | Bit 3 picks character or control; bits 2..0 pick the digit |
| din | input | 8 | Write data |
| rd_digit | input | 3 | Digit selected for the read ports |
| rd_char | output | 8 | Character byte of `rd_digit` |
| rd_flash | output | 1 | Flash bit of `rd_digit` |
| flash_bits | output | 8 | Flash bits of all digits, bit n for digit n |
| ctrl_word | output | 8 | Current control register |
| clear_busy | output | 1 | High while a clear is running |

## Verification
A clear timer whose count is off would show as `clear_busy` falling too soon or too late. Writes stuck on it or dropped after it would then show one read later, as a character that does or does not change. A wrong digit decode shows as a byte landing in a neighbour slot on the next read of all eight digits. Strobe edge errors show as a value taken from late in the pulse, or as a result that appears one cycle early or late. A clear that misses one store shows as a nonblank character or a set flash bit right after the clear starts.

// File: rtl/disp_wr_pkg.sv
package disp_wr_pkg;

    localparam int unsigned DIG_W  = 3;
    localparam int unsigned DIGITS = 1 << DIG_W;
    localparam int unsigned DATA_W = 8;
    localparam logic [DATA_W-1:0] BLANK_CODE = 8'h20;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_CHAR  = 2'd1,
        REQ_CTRL  = 2'd2,
        REQ_FLASH = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic       clr_en;
        logic       lamp_test;
        logic       spare;
        logic       blink_en;
        logic       flash_en;
        logic [2:0] bright;
    } ctrl_word_t;

    typedef struct packed {
        req_kind_e         kind;
        logic [DIG_W-1:0]  digit;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic req_kind_e classify(input logic cs_n,
                                           input logic flsel_n,
                                           input logic mode);
        if (cs_n)
            return REQ_NONE;
        else if (!flsel_n)
            return REQ_FLASH;
        else if (mode)
            return REQ_CHAR;
        else
            return REQ_CTRL;
    endfunction

endpackage

// File: rtl/wr_strobe_sync.sv
module wr_strobe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_n,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], wr_n};
            prev  <= chain[STAGES-1];
        end
    end

    assign fall = prev & ~chain[STAGES-1];

    AST_ONE_WRITE_PER_PULSE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall); // R10

endmodule

// File: rtl/clr_timer.sv
module clr_timer #(
    parameter int unsigned CLR_CYCLES = 375,
    parameter int unsigned MIN_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop_req,
    output logic busy
);
    localparam int unsigned CW = $clog2(CLR_CYCLES + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(CLR_CYCLES - 1);
    localparam logic [CW-1:0] MIN_CNT  = CW'(MIN_CYCLES);

    logic [CW-1:0] cnt;
    logic          may_stop;

    assign may_stop = (cnt >= MIN_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (stop_req && may_stop)
                busy <= 1'b0;
            else if (cnt == LAST_CNT)
                busy <= 1'b0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= LAST_CNT)); // R7

    AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(cnt) >= MIN_CNT)); // R8

    AST_STOP_TOO_SOON: assert property (@(posedge clk) disable iff (rst)
        (busy && stop_req && !start && (cnt < MIN_CNT)) |=> busy); // R8

endmodule

// File: rtl/disp_store.sv
module disp_store
    import disp_wr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  req,
    input  logic                     busy,
    input  logic                     clr_start,
    input  logic [DIG_W-1:0]         rd_digit,
    output logic [DATA_W-1:0]        rd_char,
    output logic                     rd_flash,
    output logic [DIGITS-1:0]        flash_bits
);
    logic [DATA_W-1:0]        char_mem [DIGITS];
    logic [DIGITS*DATA_W-1:0] all_chars;
    logic                     accept;

    assign accept = !busy;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic hit;
        assign hit = (req.digit == DIG_W'(g));

        always_ff @(posedge clk) begin
            if (rst || clr_start)
                char_mem[g] <= BLANK_CODE;
            else if (accept && hit && req.kind == REQ_CHAR)
                char_mem[g] <= req.data;
        end

        always_ff @(posedge clk) begin
            if (rst || clr_start)
                flash_bits[g] <= 1'b0;
            else if (accept && hit && req.kind == REQ_FLASH)
                flash_bits[g] <= req.data[0];
        end

        assign all_chars[g*DATA_W +: DATA_W] = char_mem[g];
    end

    assign rd_char  = char_mem[rd_digit];
    assign rd_flash = flash_bits[rd_digit];

    AST_RESET_BLANKS: assert property (@(posedge clk)
        rst |=> (all_chars == {DIGITS{BLANK_CODE}}) && (flash_bits == '0)); // R5

    AST_CLEAR_FILLS: assert property (@(posedge clk) disable iff (rst)
        clr_start |=> (all_chars == {DIGITS{BLANK_CODE}}) && (flash_bits == '0)); // R6

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (busy && !clr_start) |=> ($stable(all_chars) && $stable(flash_bits))); // R9

endmodule

// File: rtl/disp_wr_port.sv
module disp_wr_port
    import disp_wr_pkg::*;
#(
    parameter int unsigned CLR_CYCLES  = 375,
    parameter int unsigned MIN_CYCLES  = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 wr_n,
    input  logic                 flsel_n,
    input  logic [3:0]           addr,
    input  logic [7:0]           din,
    input  logic [2:0]           rd_digit,
    output logic [7:0]           rd_char,
    output logic                 rd_flash,
    output logic [7:0]           flash_bits,
    output logic [7:0]           ctrl_word,
    output logic                 clear_busy
);
    logic       wr_fall;
    wr_req_t    req_q;
    ctrl_word_t ctrl_q;
    logic       clr_start;
    logic       clr_stop;

    wr_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .wr_n (wr_n),
        .fall (wr_fall)
    );

    // Capture the bus on the cycle the strobe edge is seen.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '{kind: REQ_NONE, digit: '0, data: '0};
        end else if (wr_fall) begin
            req_q.kind  <= classify(cs_n, flsel_n, addr[3]);
            req_q.digit <= addr[DIG_W-1:0];
            req_q.data  <= din;
        end else begin
            req_q.kind  <= REQ_NONE;
        end
    end

    assign clr_start = (req_q.kind == REQ_CTRL) &&  req_q.data[DATA_W-1];
    assign clr_stop  = (req_q.kind == REQ_CTRL) && !req_q.data[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (req_q.kind == REQ_CTRL)
            ctrl_q <= ctrl_word_t'(req_q.data);
    end

    clr_timer #(
        .CLR_CYCLES (CLR_CYCLES),
        .MIN_CYCLES (MIN_CYCLES)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (clr_start),
        .stop_req (clr_stop),
        .busy     (clear_busy)
    );

    disp_store i_store (
        .clk        (clk),
        .rst        (rst),
        .req        (req_q),
        .busy       (clear_busy),
        .clr_start  (clr_start),
        .rd_digit   (rd_digit),
        .rd_char    (rd_char),
        .rd_flash   (rd_flash),
        .flash_bits (flash_bits)
    );

    assign ctrl_word = ctrl_q;

endmodule

// File: tb/test_disp_wr_port.sv
module test_disp_wr_port;

    localparam int CLR = 375;
    localparam int MINC = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, wr_n = 1'b1, flsel_n = 1'b1;
    logic [3:0] addr = '0;
    logic [7:0] din = '0;
    logic [2:0] rd_digit = '0;
    logic [7:0] rd_char, flash_bits, ctrl_word;
    logic       rd_flash, clear_busy;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    disp_wr_port #(.CLR_CYCLES(CLR), .MIN_CYCLES(MINC)) i_disp_wr_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .flsel_n(flsel_n),
        .addr(addr), .din(din), .rd_digit(rd_digit), .rd_char(rd_char),
        .rd_flash(rd_flash), .flash_bits(flash_bits), .ctrl_word(ctrl_word),
        .clear_busy(clear_busy)
    );

    typedef struct {
        int         kind;   // 0 char, 1 flash, 2 ctrl, 3 busy
        int         idx;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sbq[$];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic expect_item(input int kind, input int idx, input logic [7:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: pops expected items and compares against the read ports.
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() != 0) begin
                item_t it;
                it = sbq.pop_front();
                rd_digit = it.idx[2:0];
                #1;
                case (it.kind)
                    0: chk(it.tag, rd_char, it.exp);
                    1: chk(it.tag, {7'd0, rd_flash}, it.exp);
                    2: chk(it.tag, ctrl_word, it.exp);
                    default: chk(it.tag, {7'd0, clear_busy}, it.exp);
                endcase
            end
        end
    end

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic cs, input logic fl, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = cs; flsel_n = fl; addr = a; din = d; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1; flsel_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_all_chars(input logic [7:0] v, input string tag);
        for (int i = 0; i < 8; i++) expect_item(0, i, v, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v [8];
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R5 reset state
        expect_all_chars(8'h20, "R5 char after reset");
        for (int i = 0; i < 8; i++) expect_item(1, i, 8'h00, "R5 flash after reset");
        expect_item(2, 0, 8'h00, "R5 ctrl after reset");
        expect_item(3, 0, 8'h00, "R5 busy after reset");
        drain();

        // R2 character writes with both page values
        for (int i = 0; i < 8; i++) begin
            v[i] = ((i % 2) != 0 ? 8'hC0 : 8'h40) | 8'(i + 1);
            bus_write(1'b0, 1'b1, {1'b1, 3'(i)}, v[i]);
        end
        for (int i = 0; i < 8; i++) expect_item(0, i, v[i], "R2 char slot");
        drain();

        // R1 chip select high blocks all stores
        bus_write(1'b1, 1'b1, 4'b1011, 8'h55);
        bus_write(1'b1, 1'b0, 4'b0011, 8'h01);
        bus_write(1'b1, 1'b1, 4'b0000, 8'h3F);
        expect_item(0, 3, v[3], "R1 char unchanged");
        expect_item(1, 3, 8'h00, "R1 flash unchanged");
        expect_item(2, 0, 8'h00, "R1 ctrl unchanged");
        drain();

        // R4 flash writes, upper bits and addr[3] ignored
        bus_write(1'b0, 1'b0, 4'b1010, 8'h01);
        bus_write(1'b0, 1'b0, 4'b0101, 8'hFF);
        expect_item(1, 2, 8'h01, "R4 flash set d2");
        expect_item(1, 5, 8'h01, "R4 flash set d5");
        expect_item(0, 2, v[2], "R4 char untouched");
        drain();
        bus_write(1'b0, 1'b0, 4'b0010, 8'hFE);
        expect_item(1, 2, 8'h00, "R4 flash cleared by d0=0");
        expect_item(1, 5, 8'h01, "R4 other flash kept");
        drain();

        // R3 control word load, no clear
        bus_write(1'b0, 1'b1, 4'b0000, 8'h5B);
        expect_item(2, 0, 8'h5B, "R3 ctrl loaded");
        expect_item(3, 0, 8'h00, "R3 no clear");
        expect_item(0, 6, v[6], "R3 chars untouched");
        drain();

        // R10 bus change mid-pulse is not stored
        @(negedge clk);
        cs_n = 1'b0; flsel_n = 1'b1; addr = 4'b1001; din = 8'h2A; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        din = 8'h7E;
        repeat (4) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        repeat (4) @(negedge clk);
        expect_item(0, 1, 8'h2A, "R10 edge-time value");
        drain();

        // R11 write latency of three edges
        rd_digit = 3'd4;
        cs_n = 1'b0; flsel_n = 1'b1; addr = 4'b1100; din = 8'h33; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 not yet visible", rd_char, v[4]);
        @(negedge clk);
        chk("R11 visible at third edge", rd_char, 8'h33);
        repeat (3) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        repeat (4) @(negedge clk);

        // R6 clear start, R8 early stop too soon
        bus_write(1'b0, 1'b0, 4'b0111, 8'h01);
        bus_write(1'b0, 1'b1, 4'b0000, 8'h92);
        bus_write(1'b0, 1'b1, 4'b0000, 8'h13);
        expect_all_chars(8'h20, "R6 char blanked");
        expect_item(1, 7, 8'h00, "R6 flash cleared");
        expect_item(1, 5, 8'h00, "R6 flash cleared");
        expect_item(2, 0, 8'h13, "R8 ctrl loaded while busy");
        expect_item(3, 0, 8'h01, "R8 clear not ended before minimum");
        drain();

        // R9 writes dropped while busy
        bus_write(1'b0, 1'b1, 4'b1000, 8'h41);
        bus_write(1'b0, 1'b0, 4'b0001, 8'h01);
        expect_item(0, 0, 8'h20, "R9 char write dropped");
        expect_item(1, 1, 8'h00, "R9 flash write dropped");
        expect_item(3, 0, 8'h01, "R9 still busy");
        drain();

        // R8 early stop after minimum
        bus_write(1'b0, 1'b1, 4'b0000, 8'h07);
        expect_item(3, 0, 8'h00, "R8 clear ended early");
        expect_item(2, 0, 8'h07, "R8 ctrl after stop");
        drain();
        bus_write(1'b0, 1'b1, 4'b1000, 8'h41);
        expect_item(0, 0, 8'h41, "R8 char write after stop");
        drain();

        // R7 full clear length
        begin
            int n = 0;
            int k = 0;
            bit seen = 0;
            @(negedge clk);
            cs_n = 1'b0; flsel_n = 1'b1; addr = 4'b0000; din = 8'h80; wr_n = 1'b0;
            while (k < 2000) begin
                @(negedge clk);
                k++;
                if (k == 6) begin wr_n = 1'b1; cs_n = 1'b1; end
                if (clear_busy) begin seen = 1; n++; end
                else if (seen) break;
            end
            chk("R7 clear length low byte", 8'(n), 8'(CLR));
            checks++;
            if (n != CLR) begin
                errors++;
                $display("FAIL R7 clear length: actual=%0d expected=%0d", n, CLR);
            end
        end
        expect_item(2, 0, 8'h80, "R7 ctrl keeps written value");
        drain();
        bus_write(1'b0, 1'b1, 4'b1101, 8'hA5);
        expect_item(0, 5, 8'hA5, "R7 write accepted after timeout");
        drain();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule